// File: doc/BRIEF.md
# Outcome-History Branch Direction Predictor

The block guesses whether a conditional branch will be taken. It keeps a record of recent branch outcomes and uses that record as the address into a table of two-bit saturating counters. A fetch stage presents a lookup and gets a taken/not-taken guess back combinationally, in the same cycle. The lookup also returns the table index it used. When the branch resolves, the pipeline sends the real outcome on the update port together with that saved index. The update moves the counter and appends the outcome to the history.

A static-ish control pin picks the history source. In shared mode, one history register serves every branch. In per-branch mode, a small table of histories is selected by low PC bits. Both the lookup and the update stream are single-beat strobes that the block accepts in every cycle. It never applies back-pressure, so there is no ready signal, and the sender may issue a lookup and an update in the same cycle.

Top module: `bp_dir_predictor`

## Requirements
- R1: With `lkp_valid` high, `lkp_taken` is 1 in the same cycle when the counter at `lkp_index` holds 0 or 1, and 0 when it holds 2 or 3.
- R2: An update with `upd_taken`=1 lowers the counter at `upd_index` by one, and a counter already at 0 stays at 0.
- R3: An update with `upd_taken`=0 raises the counter at `upd_index` by one, and a counter already at 3 stays at 3.
- R4: After reset every counter holds 2 (weak not-taken) and every history is zero, so `lkp_index` reads 0 and every lookup predicts not taken.
- R5: In shared mode (`mode_local`=0), each update shifts the shared history left by one, with the outcome (1 = taken) entering at bit 0 and the top bit dropped; `lkp_index` shows this history.
- R6: In per-branch mode (`mode_local`=1), the history is chosen by PC bits [PC_LSB+LHT_W-1:PC_LSB]: the lookup reads the entry selected by `lkp_pc`, and an update shifts only the entry selected by `upd_pc`, as in R5. The shared history is left untouched.
- R7: The counter that an update modifies is the one at `upd_index`, whatever the current history is; the counter at the current history is unchanged unless the two are equal.
- R8: When a lookup and an update address the same counter in one cycle, the lookup returns the prediction from the value before the update.
- R9: With `lkp_valid` low, `lkp_taken` is 0.
- R10: In a cycle without `upd_valid`, no counter and no history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_local | input | 1 | 0 = shared history, 1 = per-branch history by PC |
| lkp_valid | input | 1 | Lookup strobe from fetch |
| lkp_pc | input | PC_W | PC of the branch being looked up |
| lkp_taken | output | 1 | Same-cycle direction guess, 1 = taken |
| lkp_index | output | HIST_W | Counter index used by this lookup (to be returned on update) |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | PC of the resolved branch (selects history in per-branch mode) |
| upd_index | input | HIST_W | Counter index saved from the lookup |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest state to reach from the ports is a chosen counter's value. A lookup only reads the entry that the live history points at, and every update that moves a counter also moves that history. The stimulus therefore steers the shared history to a target index by sending a series of updates, with chosen outcomes, to a spare counter. Only then does it issue the probing lookup. The same steering sets up the collision case: a pre-loaded counter is looked up in the very cycle an update flips its prediction.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd2;
  localparam ctr_t CTR_MIN   = 2'd0;
  localparam ctr_t CTR_MAX   = 2'd3;

  // Inverted encoding: low values lean taken; taken moves the counter down.
  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MIN) ? CTR_MIN : ctr_t'(c - 2'd1);
    else       return (c == CTR_MAX) ? CTR_MAX : ctr_t'(c + 2'd1);
  endfunction

  function automatic logic ctr_predict(input ctr_t c);
    return ~c[1];
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 6,
  parameter int LHT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_local,
  input  logic [LHT_W-1:0]  lkp_sel,
  input  logic              upd_valid,
  input  logic [LHT_W-1:0]  upd_sel,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] lkp_hist
);
  localparam int LHT_N = 1 << LHT_W;

  logic [HIST_W-1:0] ghist_q;
  logic [HIST_W-1:0] lhist_q [LHT_N];

  always_ff @(posedge clk) begin
    if (!rst_n) ghist_q <= '0;
    else if (upd_valid && !mode_local)
      ghist_q <= {ghist_q[HIST_W-2:0], upd_taken};
  end

  for (genvar e = 0; e < LHT_N; e++) begin : g_lht
    always_ff @(posedge clk) begin
      if (!rst_n) lhist_q[e] <= '0;
      else if (upd_valid && mode_local && upd_sel == LHT_W'(e))
        lhist_q[e] <= {lhist_q[e][HIST_W-2:0], upd_taken};
    end
  end

  assign lkp_hist = mode_local ? lhist_q[lkp_sel] : ghist_q;
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          rd_idx,
  output ctr_t                      rd_ctr,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_taken,
  output logic [2*(1<<IDX_W)-1:0]   ctr_flat
);
  localparam int N = 1 << IDX_W;

  ctr_t ctr_q [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ctr_q[e] <= CTR_RESET;
      else if (wr_en && wr_idx == IDX_W'(e))
        ctr_q[e] <= ctr_next(ctr_q[e], wr_taken);
    end
    assign ctr_flat[2*e +: 2] = ctr_q[e];
  end

  // Registered storage: a same-cycle read sees the value before the write.
  assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor
  import bp_pkg::*;
#(
  parameter int HIST_W = 6,
  parameter int LHT_W  = 3,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_local,
  input  logic              lkp_valid,
  input  logic [PC_W-1:0]   lkp_pc,
  output logic              lkp_taken,
  output logic [HIST_W-1:0] lkp_index,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_index,
  input  logic              upd_taken
);
  localparam int N = 1 << HIST_W;

  logic [LHT_W-1:0]  lkp_sel, upd_sel;
  logic [HIST_W-1:0] hist;
  ctr_t              rd_ctr;
  logic [2*N-1:0]    ctr_flat;
  logic              unused_pc_bits;

  assign lkp_sel = lkp_pc[PC_LSB +: LHT_W];
  assign upd_sel = upd_pc[PC_LSB +: LHT_W];
  assign unused_pc_bits = ^{lkp_pc, upd_pc};

  bp_history #(.HIST_W(HIST_W), .LHT_W(LHT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .mode_local(mode_local),
    .lkp_sel(lkp_sel), .upd_valid(upd_valid), .upd_sel(upd_sel),
    .upd_taken(upd_taken), .lkp_hist(hist)
  );

  bp_counter_table #(.IDX_W(HIST_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .rd_idx(hist), .rd_ctr(rd_ctr),
    .wr_en(upd_valid), .wr_idx(upd_index), .wr_taken(upd_taken),
    .ctr_flat(ctr_flat)
  );

  assign lkp_index = hist;
  assign lkp_taken = lkp_valid & ctr_predict(rd_ctr);
endmodule

// File: rtl/bp_dir_predictor_chk.sv
module bp_dir_predictor_chk #(
  parameter int HIST_W = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mode_local,
  input logic                      lkp_valid,
  input logic                      lkp_taken,
  input logic [HIST_W-1:0]         lkp_index,
  input logic                      upd_valid,
  input logic [HIST_W-1:0]         upd_index,
  input logic                      upd_taken,
  input logic [2*(1<<HIST_W)-1:0]  ctr_flat
);
  logic [HIST_W:0]   upd_pos, lkp_pos, d_pos;
  logic [HIST_W-1:0] idx_d;
  logic [1:0]        ctr_at_upd, ctr_at_d, ctr_at_lkp;

  always_ff @(posedge clk) idx_d <= upd_index;

  assign upd_pos    = {upd_index, 1'b0};
  assign lkp_pos    = {lkp_index, 1'b0};
  assign d_pos      = {idx_d, 1'b0};
  assign ctr_at_upd = ctr_flat[upd_pos +: 2];
  assign ctr_at_lkp = ctr_flat[lkp_pos +: 2];
  assign ctr_at_d   = ctr_flat[d_pos +: 2];

  p_pred_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |-> (lkp_taken == (ctr_at_lkp < 2'd2)));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr_at_upd != 2'd0) |=> ctr_at_d == $past(ctr_at_upd) - 2'd1);

  p_dec_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr_at_upd == 2'd0) |=> ctr_at_d == 2'd0);

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr_at_upd != 2'd3) |=> ctr_at_d == $past(ctr_at_upd) + 2'd1);

  p_inc_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr_at_upd == 2'd3) |=> ctr_at_d == 2'd3);

  p_gshift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !mode_local) |=>
      (mode_local || lkp_index == {$past(lkp_index[HIST_W-2:0]), $past(upd_taken)}));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> !lkp_taken);

  p_ctr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ctr_flat));

  p_ghold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !mode_local) |=> (mode_local || $stable(lkp_index)));
endmodule

bind bp_dir_predictor bp_dir_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_local(mode_local),
  .lkp_valid(lkp_valid), .lkp_taken(lkp_taken), .lkp_index(lkp_index),
  .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken),
  .ctr_flat(ctr_flat)
);

// File: tb/bp_dir_predictor_tb_top.sv
module bp_dir_predictor_tb_top;
  localparam int HW = 6, LW = 3, PW = 32, PL = 2;
  localparam int N = 1 << HW, LN = 1 << LW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mode_local, lkp_valid, lkp_taken, upd_valid, upd_taken;
  logic [PW-1:0] lkp_pc, upd_pc;
  logic [HW-1:0] lkp_index, upd_index;

  bp_dir_predictor #(.HIST_W(HW), .LHT_W(LW), .PC_W(PW), .PC_LSB(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_local(mode_local),
    .lkp_valid(lkp_valid), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
    .lkp_index(lkp_index), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_index(upd_index), .upd_taken(upd_taken)
  );

  int checks = 0, fails = 0;
  logic [1:0]    m_cnt [N];
  logic [HW-1:0] m_gh;
  logic [HW-1:0] m_lht [LN];

  function automatic logic [LW-1:0] sel(input logic [PW-1:0] pc);
    return pc[PL +: LW];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_cnt[i] = 2'd2;
    for (int i = 0; i < LN; i++) m_lht[i] = '0;
    m_gh = '0;
  endtask

  // One cycle: drive, check the combinational lookup, then advance the model.
  task automatic cyc(input logic lv, input logic [PW-1:0] lpc, input logic uv,
                     input logic [PW-1:0] upc, input logic [HW-1:0] uidx,
                     input logic utk, input string req);
    logic [HW-1:0] ei;
    @(negedge clk);
    lkp_valid = lv; lkp_pc = lpc; upd_valid = uv; upd_pc = upc;
    upd_index = uidx; upd_taken = utk;
    #1;
    ei = mode_local ? m_lht[sel(lpc)] : m_gh;
    chk(req, "lkp_index", int'(lkp_index), int'(ei));
    chk(req, "lkp_taken", int'(lkp_taken), int'(lv && m_cnt[ei] < 2'd2));
    @(posedge clk);
    if (uv) begin
      if (utk) m_cnt[uidx] = (m_cnt[uidx] == 2'd0) ? 2'd0 : m_cnt[uidx] - 2'd1;
      else     m_cnt[uidx] = (m_cnt[uidx] == 2'd3) ? 2'd3 : m_cnt[uidx] + 2'd1;
      if (mode_local) m_lht[sel(upc)] = {m_lht[sel(upc)][HW-2:0], utk};
      else            m_gh = {m_gh[HW-2:0], utk};
    end
  endtask

  // Steer the shared history to v using updates to the spare entry N-1.
  task automatic set_hist(input logic [HW-1:0] v);
    for (int i = HW - 1; i >= 0; i--) cyc(1'b0, '0, 1'b1, '0, HW'(N - 1), v[i], "R5");
  endtask

  task automatic probe(input logic [HW-1:0] x, input string req);
    set_hist(x);
    cyc(1'b1, 32'h40, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic t_reset();
    chk("R4", "index after reset", int'(lkp_index), 0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 32'h1000 + 32'(i * 4), 1'b0, '0, '0, 1'b0, "R4");
    mode_local = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 32'h2000 + 32'(i * 4), 1'b0, '0, '0, 1'b0, "R4");
    mode_local = 1'b0;
  endtask

  task automatic t_idle();
    cyc(1'b0, '0, 1'b1, '0, HW'(0), 1'b1, "R9");
    cyc(1'b0, '0, 1'b1, '0, HW'(0), 1'b1, "R9");
    set_hist('0);
    cyc(1'b0, 32'h40, 1'b0, '0, '0, 1'b0, "R9");
    chk("R9", "taken with lookup idle", int'(lkp_taken), 0);
    cyc(1'b1, 32'h40, 1'b0, '0, '0, 1'b0, "R1");
    chk("R1", "entry 0 at value 0 predicts", int'(lkp_taken), 1);
  endtask

  task automatic t_dec_sat();
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, '0, 1'b1, '0, HW'(9), 1'b1, "R2");
      probe(HW'(9), "R2");
    end
    for (int i = 0; i < 2; i++) begin
      cyc(1'b0, '0, 1'b1, '0, HW'(9), 1'b0, "R2");
      probe(HW'(9), "R2");
    end
  endtask

  task automatic t_inc_sat();
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, '0, 1'b1, '0, HW'(22), 1'b0, "R3");
      probe(HW'(22), "R3");
    end
    for (int i = 0; i < 2; i++) begin
      cyc(1'b0, '0, 1'b1, '0, HW'(22), 1'b1, "R3");
      probe(HW'(22), "R3");
    end
  endtask

  task automatic t_ghist();
    logic [9:0] pat = 10'b1101001110;
    for (int i = 0; i < 10; i++) cyc(1'b1, 32'h80, 1'b1, '0, HW'(40), pat[i], "R5");
    cyc(1'b1, 32'h80, 1'b0, '0, '0, 1'b0, "R5");
  endtask

  task automatic t_local();
    logic [HW-1:0] g_before;
    g_before = m_gh;
    mode_local = 1'b1;
    cyc(1'b1, 32'h104, 1'b1, 32'h100, HW'(17), 1'b1, "R6");
    cyc(1'b1, 32'h100, 1'b1, 32'h104, HW'(18), 1'b0, "R6");
    cyc(1'b1, 32'h104, 1'b1, 32'h104, HW'(18), 1'b1, "R6");
    cyc(1'b1, 32'h120, 1'b1, 32'h11c, HW'(19), 1'b1, "R6");
    cyc(1'b1, 32'h11c, 1'b0, '0, '0, 1'b0, "R6");
    cyc(1'b1, 32'h108, 1'b0, '0, '0, 1'b0, "R6");
    mode_local = 1'b0;
    cyc(1'b1, 32'h100, 1'b0, '0, '0, 1'b0, "R6");
    chk("R6", "shared history untouched in per-branch mode", int'(lkp_index), int'(g_before));
  endtask

  task automatic t_stale_idx();
    set_hist(HW'(3));
    cyc(1'b1, 32'h40, 1'b1, '0, HW'(50), 1'b1, "R7");
    cyc(1'b1, 32'h40, 1'b1, '0, HW'(50), 1'b1, "R7");
    probe(HW'(50), "R7");
    chk("R7", "saved index entry now taken", int'(lkp_taken), 1);
    probe(HW'(3), "R7");
  endtask

  task automatic t_same_cycle();
    cyc(1'b0, '0, 1'b1, '0, HW'(12), 1'b1, "R8");
    set_hist(HW'(12));
    cyc(1'b1, 32'h40, 1'b1, '0, HW'(12), 1'b0, "R8");
    chk("R8", "collision returns pre-update guess", int'(lkp_taken), 1);
    probe(HW'(12), "R8");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 6; i++) cyc(1'b1, 32'h200 + 32'(i * 4), 1'b0, '0, HW'(i), 1'b1, "R10");
    mode_local = 1'b1;
    for (int i = 0; i < 6; i++) cyc(1'b1, 32'h100 + 32'(i * 4), 1'b0, '0, HW'(i), 1'b0, "R10");
    mode_local = 1'b0;
    cyc(1'b1, 32'h40, 1'b0, '0, '0, 1'b0, "R10");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_local = 1'b0; lkp_valid = 1'b0; lkp_pc = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_index = '0; upd_taken = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_idle();
    t_dec_sat();
    t_inc_sat();
    t_ghist();
    t_local();
    t_stale_idx();
    t_same_cycle();
    t_hold();
    finish_run();
  end
endmodule